// File: doc/BRIEF.md
# Mode-Encoded Reference Clock Divider

This block divides an incoming reference clock by an integer ratio between 1 and 2055. The ratio does not arrive as a plain binary count. It arrives as a 13-bit control field, and the two low bits of that field select how the rest is read. The first format gives ratios 1 and 2. The second is a short inverted field for the small ratios. The third is an offset long field for ratios from 8 up to 2055. The block decodes the field and reports the resulting ratio. It emits a one-cycle enable pulse every N reference cycles, and that pulse feeds a phase comparator further on.

A new field can be written at any time. The divider adopts the new ratio only when its current count reaches its end. The period in progress therefore always finishes at the old ratio, so the output never has a shortened period. With a ratio of 1, the enable stays high on every cycle and passes the reference rate straight through.

Top module: `enc_ref_div`

## Requirements
- R1: `ratio_o` always lies between 1 and 2055 inclusive, whatever the value of `cfg_i`.
- R2: When `cfg_i[1]` is 0, `ratio_o` equals 1 + `cfg_i[0]`, and bits 12..2 have no effect.
- R3: When `cfg_i[1:0]` is 2'b10, `ratio_o` equals the bitwise inverse of the 4-bit value `cfg_i[5:2]`, plus 2. Bits 12..6 have no effect.
- R4: When `cfg_i[1:0]` is 2'b11, `ratio_o` equals the unsigned value of `cfg_i[12:2]` plus 8.
- R5: For an active ratio N of 2 or more, `pulse_o` is high for exactly one clock cycle and low for the N-1 cycles that follow.
- R6: For an active ratio of 1, `pulse_o` is high on every clock cycle.
- R7: The active ratio is reloaded from the decoded `cfg_i` only on a clock edge at which `pulse_o` is high. A field change made in mid-period does not alter the current period. The period that starts on that edge uses the new ratio.
- R8: While `rst_ni` is low, `pulse_o` is high. The first rising edge after reset loads the ratio decoded from `cfg_i` at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 13 | Mode-encoded ratio field |
| ratio_o | output | 12 | Ratio decoded from `cfg_i` |
| pulse_o | output | 1 | One-cycle enable at each divided period |

## Verification
The decoder's assertions check every cycle that the ratio stays within range for each format. The counter's assertions check every cycle that it stays below the active ratio, that the active ratio never changes away from a terminal count, and that the cycle after a pulse matches the newly loaded ratio. The exact period lengths can only be shown by the bench's scenarios. The same holds for the decoded value of specific fields, for the behaviour of the upper bits that must be ignored, and for a field rewritten in the middle of a period. The bench's cycle-by-cycle model compares all of these.

// File: rtl/enc_ref_div_pkg.sv
package enc_ref_div_pkg;
  localparam int unsigned CFG_W     = 13;
  localparam int unsigned SEL_W     = 2;
  localparam int unsigned SHORT_W   = 4;
  localparam int unsigned LONG_W    = CFG_W - SEL_W;
  localparam int unsigned SHORT_OFS = 2;
  localparam int unsigned LONG_OFS  = 8;
  localparam int unsigned RATIO_MAX = (1 << LONG_W) - 1 + LONG_OFS;
  localparam int unsigned RATIO_W   = $clog2(RATIO_MAX + 1);

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_SHORT  = 2'd1,
    MODE_LONG   = 2'd2
  } fmt_e;

  typedef logic [RATIO_W-1:0] ratio_t;
endpackage

// File: rtl/enc_ref_div_decode.sv
module enc_ref_div_decode
  import enc_ref_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output ratio_t           ratio_o
);
  fmt_e               fmt;
  logic [SHORT_W-1:0] short_inv;

  always_comb begin
    if (!cfg_i[1])     fmt = MODE_DIRECT;
    else if (cfg_i[0]) fmt = MODE_LONG;
    else               fmt = MODE_SHORT;
  end

  assign short_inv = ~cfg_i[SEL_W +: SHORT_W];

  always_comb begin
    unique case (fmt)
      MODE_DIRECT: ratio_o = ratio_t'(1) + ratio_t'(cfg_i[0]);
      MODE_SHORT:  ratio_o = ratio_t'(short_inv) + ratio_t'(SHORT_OFS);
      MODE_LONG:   ratio_o = ratio_t'(cfg_i[SEL_W +: LONG_W]) + ratio_t'(LONG_OFS);
      default:     ratio_o = ratio_t'(1);
    endcase
  end

  a_r1_ratio_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_o >= ratio_t'(1)) && (ratio_o <= ratio_t'(RATIO_MAX)));
  a_r2_direct_small: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i[1] |-> ratio_o <= ratio_t'(2));
  a_r3_short_band: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[1:0] == 2'b10) |-> (ratio_o >= ratio_t'(2) && ratio_o <= ratio_t'(17)));
  a_r4_long_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i[1:0] == 2'b11) |-> ratio_o >= ratio_t'(LONG_OFS));
endmodule

// File: rtl/enc_ref_div_counter.sv
module enc_ref_div_counter
  import enc_ref_div_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  ratio_t next_ratio_i,
  output logic   tick_o
);
  ratio_t act_q, cnt_q;

  assign tick_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= ratio_t'(1);
      cnt_q <= '0;
    end else if (tick_o) begin
      // reload only at terminal count
      act_q <= next_ratio_i;
      cnt_q <= next_ratio_i - ratio_t'(1);
    end else begin
      cnt_q <= cnt_q - ratio_t'(1);
    end
  end

  a_r5_count_below_ratio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < act_q);
  a_r7_hold_mid_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(act_q));
  a_r6_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (tick_o == (act_q == ratio_t'(1))));
  a_r7_load_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (act_q == $past(next_ratio_i)));
endmodule

// File: rtl/enc_ref_div.sv
module enc_ref_div
  import enc_ref_div_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CFG_W-1:0]    cfg_i,
  output logic [RATIO_W-1:0]  ratio_o,
  output logic                pulse_o
);
  ratio_t dec_ratio;

  enc_ref_div_decode i_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg_i),
    .ratio_o (dec_ratio)
  );

  enc_ref_div_counter i_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .next_ratio_i (dec_ratio),
    .tick_o       (pulse_o)
  );

  assign ratio_o = dec_ratio;

  a_r8_reset_pulse: assert property (@(posedge clk_i)
    !rst_ni |-> pulse_o);
endmodule

// File: tb/test_enc_ref_div.sv
module test_enc_ref_div;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] cfg_i = '0;
  logic [11:0] ratio_o;
  logic        pulse_o;

  int total = 0;
  int bad = 0;
  bit run_cmp = 1'b0;
  int m_left;
  int m_act;

  always #2 clk_i = ~clk_i;

  enc_ref_div i_enc_ref_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cfg_i   (cfg_i),
    .ratio_o (ratio_o),
    .pulse_o (pulse_o)
  );

  function automatic int exp_ratio(input logic [12:0] c);
    if (c[1] == 1'b0) return 1 + int'(c[0]);
    if (c[0] == 1'b0) return 17 - int'(c[5:2]);
    return int'(c[12:2]) + 8;
  endfunction

  function automatic logic [12:0] enc_short(input int n);
    logic [3:0] f;
    f = 4'(17 - n);
    return {7'b0, f, 2'b10};
  endfunction

  function automatic logic [12:0] enc_long(input int n);
    logic [10:0] f;
    f = 11'(n - 8);
    return {f, 2'b11};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_dec(input string req, input logic [12:0] c, input int exp);
    cfg_i = c;
    #1;
    check(req, int'(ratio_o), exp);
  endtask

  // behavioural model of periods remaining
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_left = 0;
      m_act  = 1;
    end else if (m_left == 0) begin
      m_act  = exp_ratio(cfg_i);
      m_left = m_act - 1;
    end else begin
      m_left = m_left - 1;
    end
  end

  always @(negedge clk_i) begin
    if (run_cmp && rst_ni) begin
      if (m_act == 1) check("R6", int'(pulse_o), 1);
      else            check("R5/R7", int'(pulse_o), (m_left == 0) ? 1 : 0);
    end
  end

  task automatic run(input logic [12:0] c, input int cycles);
    @(negedge clk_i);
    cfg_i = c;
    repeat (cycles) @(negedge clk_i);
  endtask

  initial begin
    // decode checks
    chk_dec("R2", 13'h0000, 1);
    chk_dec("R2", 13'h0001, 2);
    chk_dec("R2", 13'h1FFC, 1);
    chk_dec("R2", 13'h1FFD, 2);
    chk_dec("R3", 13'b0000000_1111_10, 2);
    chk_dec("R3", 13'b0000000_0000_10, 17);
    chk_dec("R3", 13'b0000000_1110_10, 3);
    chk_dec("R3", 13'b1111111_1100_10, 5);
    chk_dec("R4", 13'b00000000000_11, 8);
    chk_dec("R4", 13'h1FFF, 2055);
    chk_dec("R4", 13'b00000000001_11, 9);
    chk_dec("R4", enc_long(1000), 1000);
    chk_dec("R1", 13'h1FFF, 2055);
    cfg_i = enc_short(4);
    #1;
    check("R8", int'(pulse_o), 1);
    @(negedge clk_i);
    check("R8", int'(pulse_o), 1);
    run_cmp = 1'b1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (12) @(negedge clk_i);
    run(13'h0000, 20);
    run(13'h0001, 20);
    run(enc_short(3), 30);
    run(enc_short(17), 60);
    run(enc_short(2), 20);
    run(enc_long(8), 40);
    // mid-period rewrite: R7
    run(enc_long(40), 45);
    run(enc_short(5), 60);
    run(enc_long(9), 4);
    run(13'h0000, 30);
    run(enc_long(2055), 4200);
    run(enc_short(3), 20);
    run_cmp = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule